// File: doc/BRIEF.md
# Byte-Level I2C Bus Master with Host Handshake

This block is a two-wire serial bus master that advances one bus phase at a time. A host works it through a small register-style interface: a control register written through separate set and clear strobes, a data register and a read-only status byte. Each completed phase (a START, an address byte, a data byte or a lost arbitration) raises an interrupt flag and posts an 8-bit status code. SCL is then held low until the host clears the flag, so software decides the next step from the code.

Both bus lines are open-drain. The block drives a line low by asserting its output enable and reads the line back on a separate input. The SCL low and high periods are set in clock cycles by two programmable count registers. The block supports master transmit and master receive. A repeated START lets the host change direction without releasing the bus. A bus monitor tracks START and STOP conditions made by any master, so a new START waits for a free bus.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status reads 0xF8, the interrupt output is 0, the control register reads 0, and neither line is driven.
- R2: Control bit positions are: bit 6 enable, bit 5 START request, bit 4 STOP request, bit 3 interrupt flag, bit 2 acknowledge enable. Bits 7, 1 and 0 read as 0. A set-write to bit 3 has no effect. A clear-write to bit 3 clears the flag.
- R3: While enable is 0 the block drives neither line and raises no flag, even with a START request pending. Setting enable later lets the pending START proceed.
- R4: A START request is served only once the bus is free. The bus is busy from any START seen on the lines until the next STOP. The START posts 0x08 and the START bit clears itself.
- R5: After an address byte whose bit 0 is 0 (write), the status is 0x18 when the slave acknowledges and 0x20 when it does not.
- R6: After an address byte whose bit 0 is 1 (read), the status is 0x40 when the slave acknowledges and 0x48 when it does not.
- R7: In transmit mode the data byte goes out MSB first. The status is 0x28 when the slave acknowledges and 0x30 when it does not.
- R8: In receive mode the byte is shifted in MSB first and appears in the data register. The master sends ACK when acknowledge enable is 1 (status 0x50) and NACK when it is 0 (status 0x58).
- R9: A START request made while the block owns the bus posts 0x10. A following address with the other direction bit switches the mode.
- R10: A STOP request (acted on when the flag is cleared) drives a STOP and releases both lines. The STOP bit then clears itself, no flag is raised, and the status reads 0xF8.
- R11: If the block releases SDA in a bit it sends but samples SDA low while SCL is high, it posts 0x38, releases both lines at once and gives up the bus.
- R12: While the flag is set after a phase on an owned bus, SCL stays driven low and the status stays unchanged.
- R13: Within a byte, SCL is released for exactly the high count and driven low between bits for exactly the low count (a count of 0 acts as 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_set_we | input | 1 | Set the control bits that are 1 in ctl_wdata |
| ctl_clr_we | input | 1 | Clear the control bits that are 1 in ctl_wdata |
| ctl_wdata | input | 8 | Control write mask |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| hi_we | input | 1 | Load the SCL high count |
| lo_we | input | 1 | Load the SCL low count |
| per_wdata | input | CW | Count value for hi_we / lo_we |
| ctl_q | output | 8 | Control register readback |
| dat_q | output | 8 | Data register readback |
| stat_q | output | 8 | Status code, 0xF8 when no flag pending |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |

## Verification
A wrong sequencer state shows up at the ports within one bus phase. The status code posted at the next flag is wrong, or the flag never comes. A slave model on the lines sees bits shifted in the wrong order or misses an acknowledge slot. A stuck bus-busy or ownership state shows up as a START that never comes, or as 0x10 where 0x08 was due. An SDA edge while SCL is high is a false START or STOP, which the slave model and the bus monitor act on at once. A wrong period counter shows up as a wrong SCL pulse width, measured directly in the cycles of the first bit.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int CW      = 8,
  parameter int PER_RST = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_set_we,
  input  logic          ctl_clr_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          dat_we,
  input  logic [7:0]    dat_wdata,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [CW-1:0] per_wdata,
  output logic [7:0]    ctl_q,
  output logic [7:0]    dat_q,
  output logic [7:0]    stat_q,
  output logic          irq,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [CW-1:0] PER0 = CW'(PER_RST);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_BIT, S_STOP} st_t;
  st_t st;

  logic en, sta, sto, si, aa, own, busy, rxm, addr_nx, addr_ph;
  logic sda_d, scl_d, scl_r, sda_r;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh, dat, code;
  logic [CW-1:0] tmr, hi_per, lo_per;

  wire sends = addr_ph | ~rxm;
  wire tdlo  = ({1'b0, tmr} + 1'b1) >= {1'b0, lo_per};
  wire tdhi  = ({1'b0, tmr} + 1'b1) >= {1'b0, hi_per};

  function automatic logic drv(input logic snd, input logic [3:0] n, input logic b, input logic a);
    return (n < 4'd8) ? (snd & ~b) : (snd ? 1'b0 : a);
  endfunction

  assign ctl_q  = {1'b0, en, sta, sto, si, aa, 2'b00};
  assign dat_q  = dat;
  assign stat_q = si ? code : 8'hF8;
  assign irq    = si;
  assign scl_oe = scl_r;
  assign sda_oe = sda_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; dat <= '0; code <= 8'hF8;
      tmr <= '0; hi_per <= PER0; lo_per <= PER0;
      en <= 1'b0; sta <= 1'b0; sto <= 1'b0; si <= 1'b0; aa <= 1'b0;
      own <= 1'b0; busy <= 1'b0; rxm <= 1'b0; addr_nx <= 1'b0; addr_ph <= 1'b0;
      sda_d <= 1'b1; scl_d <= 1'b1; scl_r <= 1'b0; sda_r <= 1'b0;
    end else begin
      sda_d <= sda_in;
      scl_d <= scl_in;
      if (scl_d && scl_in && sda_d && !sda_in)      busy <= 1'b1;
      else if (scl_d && scl_in && !sda_d && sda_in) busy <= 1'b0;

      if (ctl_set_we) begin
        en  <= en  | ctl_wdata[6];
        sta <= sta | ctl_wdata[5];
        sto <= sto | ctl_wdata[4];
        aa  <= aa  | ctl_wdata[2];
      end
      if (ctl_clr_we) begin
        if (ctl_wdata[6]) en  <= 1'b0;
        if (ctl_wdata[5]) sta <= 1'b0;
        if (ctl_wdata[4]) sto <= 1'b0;
        if (ctl_wdata[3]) si  <= 1'b0;
        if (ctl_wdata[2]) aa  <= 1'b0;
      end
      if (dat_we) dat <= dat_wdata;
      if (hi_we)  hi_per <= per_wdata;
      if (lo_we)  lo_per <= per_wdata;

      tmr <= tmr + 1'b1;
      case (st)
        S_IDLE: begin
          scl_r <= 1'b0;
          sda_r <= 1'b0;
          if (sto) sto <= 1'b0;
          else if (sta && !busy && !si) begin
            st <= S_START; ph <= 2'd1; tmr <= '0;
          end
        end
        S_START: case (ph)
          2'd0: if (tdlo) begin scl_r <= 1'b0; ph <= 2'd1; tmr <= '0; end
          2'd1: if (tdhi) begin sda_r <= 1'b1; ph <= 2'd2; tmr <= '0; end
          2'd2: if (tdhi) begin scl_r <= 1'b1; ph <= 2'd3; tmr <= '0; end
          default: if (tdlo) begin
            si <= 1'b1; code <= own ? 8'h10 : 8'h08;
            own <= 1'b1; sta <= 1'b0; addr_nx <= 1'b1; st <= S_HOLD;
          end
        endcase
        S_HOLD: begin
          scl_r <= 1'b1;
          if (!si) begin
            tmr <= '0; ph <= 2'd0;
            if (sto) begin
              st <= S_STOP; sda_r <= 1'b1;
            end else if (sta) begin
              st <= S_START; sda_r <= 1'b0;
            end else begin
              st <= S_BIT; bitn <= '0; sh <= dat;
              if (addr_nx) begin
                rxm <= dat[0]; addr_ph <= 1'b1; addr_nx <= 1'b0; sda_r <= ~dat[7];
              end else begin
                addr_ph <= 1'b0; sda_r <= rxm ? 1'b0 : ~dat[7];
              end
            end
          end
        end
        S_BIT: begin
          if (ph == 2'd0) begin
            if (tdlo) begin scl_r <= 1'b0; ph <= 2'd1; tmr <= '0; end
          end else if (tdhi) begin
            if (bitn != 4'd8) begin
              if (sends && sh[7] && !sda_in) begin
                st <= S_IDLE; own <= 1'b0; si <= 1'b1; code <= 8'h38;
                scl_r <= 1'b0; sda_r <= 1'b0;
              end else begin
                sh <= {sh[6:0], sda_in}; bitn <= bitn + 1'b1;
                ph <= 2'd0; tmr <= '0; scl_r <= 1'b1;
                sda_r <= drv(sends, bitn + 1'b1, sh[6], aa);
              end
            end else begin
              scl_r <= 1'b1; si <= 1'b1; st <= S_HOLD;
              if (addr_ph) code <= rxm ? (sda_in ? 8'h48 : 8'h40) : (sda_in ? 8'h20 : 8'h18);
              else         code <= rxm ? (aa ? 8'h50 : 8'h58) : (sda_in ? 8'h30 : 8'h28);
              if (rxm && !addr_ph) dat <= sh;
            end
          end
        end
        default: case (ph)
          2'd0: if (tdlo) begin scl_r <= 1'b0; ph <= 2'd1; tmr <= '0; end
          2'd1: if (tdhi) begin sda_r <= 1'b0; ph <= 2'd2; tmr <= '0; end
          default: if (tdhi) begin st <= S_IDLE; own <= 1'b0; sto <= 1'b0; end
        endcase
      endcase

      if (!en) begin
        st <= S_IDLE; scl_r <= 1'b0; sda_r <= 1'b0; own <= 1'b0;
      end
    end
  end

  // R3
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R12
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && own) |-> scl_oe);

  // R4
  code_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_q[2:0] == 3'b000));

  // R7
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R11
  lost_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && stat_q == 8'h38) |-> (!scl_oe && !sda_oe && !own));
endmodule

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_set_we = 0, ctl_clr_we = 0, dat_we = 0, hi_we = 0, lo_we = 0;
  logic [7:0] ctl_wdata = 0, dat_wdata = 0, per_wdata = 0;
  logic [7:0] ctl_q, dat_q, stat_q;
  logic irq, scl_oe, sda_oe;
  logic s_oe = 0, bully = 0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | s_oe | bully);

  always #2 clk = ~clk;

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_set_we(ctl_set_we), .ctl_clr_we(ctl_clr_we),
    .ctl_wdata(ctl_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata), .hi_we(hi_we),
    .lo_we(lo_we), .per_wdata(per_wdata), .ctl_q(ctl_q), .dat_q(dat_q), .stat_q(stat_q),
    .irq(irq), .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // slave model
  int sb = -1;
  logic addrph = 0, s_rd = 0, s_off = 0, m_ack = 0;
  logic s_ack_addr = 1, s_ack_data = 1;
  logic [7:0] ssh = 0, stx = 0, s_txbyte = 0, s_rx = 0;

  always @(negedge sda) if (scl === 1'b1) begin
    sb = -1; addrph = 1; s_oe = 0; s_off = 0; s_rd = 0;
  end
  always @(posedge sda) if (scl === 1'b1) s_oe = 0;
  always @(posedge scl) begin
    if (sb >= 0 && sb < 8) ssh = {ssh[6:0], sda};
    else if (sb == 8) m_ack = ~sda;
  end
  always @(negedge scl) begin
    if (sb < 0) sb = 0;
    else if (sb == 7) begin
      if (addrph) begin
        s_rd = ssh[0]; s_oe = s_ack_addr; s_off = ~s_ack_addr;
      end else if (!s_rd) begin
        s_rx = ssh; s_oe = s_ack_data;
      end else s_oe = 0;
      sb = 8;
    end else if (sb == 8) begin
      s_oe = 0;
      if (s_rd && !s_off && (addrph ? s_ack_addr : m_ack)) begin
        stx = s_txbyte; s_oe = ~stx[7];
      end
      addrph = 0; sb = 0;
    end else begin
      if (s_rd && !addrph && !s_off) s_oe = ~stx[6-sb];
      sb = sb + 1;
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cset(input logic [7:0] m);
    @(negedge clk) ctl_set_we = 1; ctl_wdata = m;
    @(negedge clk) ctl_set_we = 0;
  endtask
  task automatic cclr(input logic [7:0] m);
    @(negedge clk) ctl_clr_we = 1; ctl_wdata = m;
    @(negedge clk) ctl_clr_we = 0;
  endtask
  task automatic wdat(input logic [7:0] v);
    @(negedge clk) dat_we = 1; dat_wdata = v;
    @(negedge clk) dat_we = 0;
  endtask
  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    if (!irq) chk(1'b0, {req, " irq timeout"}, 8'h0, 8'h1);
  endtask
  task automatic do_stop();
    cset(8'h10); cclr(8'h08);
    repeat (80) @(negedge clk);
    chk(stat_q == 8'hF8 && !irq, "R10 status after stop", stat_q, 8'hF8);
    chk(ctl_q[4] == 1'b0, "R10 stop bit self-clear", ctl_q, {3'b0, ~ctl_q[4], 4'b0} & ctl_q);
    chk(!scl_oe && !sda_oe, "R10 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  // {addr, byte, slave_ack_addr, slave_ack_data, aa, exp_addr_status, exp_data_status}
  localparam logic [34:0] VEC [6] = '{
    {8'hA4, 8'h5A, 3'b110, 8'h18, 8'h28},
    {8'hA4, 8'h3C, 3'b100, 8'h18, 8'h30},
    {8'h42, 8'h00, 3'b000, 8'h20, 8'h00},
    {8'hA5, 8'hC3, 3'b100, 8'h40, 8'h58},
    {8'h43, 8'h00, 3'b000, 8'h48, 8'h00},
    {8'h91, 8'h7E, 3'b101, 8'h40, 8'h50}
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(stat_q == 8'hF8, "R1 status", stat_q, 8'hF8);
    chk(!irq && ctl_q == 8'h00, "R1 ctl/irq", ctl_q, 8'h00);
    chk(!scl_oe && !sda_oe, "R1 lines", {6'b0, scl_oe, sda_oe}, 8'h00);

    per_wdata = 8'd4;
    @(negedge clk) hi_we = 1; lo_we = 1;
    @(negedge clk) hi_we = 0; lo_we = 0;

    // R2: unused bits and flag set-write ignored
    cset(8'h8B);
    chk(ctl_q == 8'h00 && !irq, "R2 unused/flag set ignored", ctl_q, 8'h00);

    // R3: pending START while disabled
    cset(8'h20);
    repeat (60) @(negedge clk);
    chk(!irq && !scl_oe && !sda_oe, "R3 quiet while disabled", {irq, 5'b0, scl_oe, sda_oe}, 8'h00);
    chk(ctl_q == 8'h20, "R2 start bit position", ctl_q, 8'h20);
    cset(8'h40);
    wait_irq("R3");
    chk(stat_q == 8'h08, "R3 start after enable", stat_q, 8'h08);
    chk(ctl_q == 8'h48, "R2 flag bit / R4 start self-clear", ctl_q, 8'h48);
    // R12 stall
    repeat (50) @(negedge clk);
    chk(scl_oe && stat_q == 8'h08, "R12 SCL held during flag", stat_q, 8'h08);
    do_stop();

    foreach (VEC[i]) begin
      logic [7:0] a, b, ea, ed;
      logic sa, sd, av;
      {a, b, sa, sd, av, ea, ed} = VEC[i];
      s_ack_addr = sa; s_ack_data = sd; s_txbyte = b;
      if (av) cset(8'h04); else cclr(8'h04);
      cset(8'h20);
      wait_irq("R4");
      chk(stat_q == 8'h08, "R4 start status", stat_q, 8'h08);
      wdat(a); cclr(8'h08);
      wait_irq(a[0] ? "R6" : "R5");
      chk(stat_q == ea, a[0] ? "R6 read address status" : "R5 write address status", stat_q, ea);
      if (sa) begin
        if (!a[0]) begin
          wdat(b); cclr(8'h08);
          wait_irq("R7");
          chk(stat_q == ed, "R7 data status", stat_q, ed);
          chk(s_rx == b, "R7 byte seen by slave", s_rx, b);
        end else begin
          cclr(8'h08);
          wait_irq("R8");
          chk(stat_q == ed, "R8 receive status", stat_q, ed);
          chk(dat_q == b, "R8 received byte", dat_q, b);
          if (av) begin
            cclr(8'h0C);
            wait_irq("R8");
            chk(stat_q == 8'h58, "R8 nack after clearing aa", stat_q, 8'h58);
            chk(dat_q == b, "R8 second byte", dat_q, b);
          end
        end
      end
      do_stop();
    end

    // R13 timing, then R9 repeated START
    per_wdata = 8'd5;
    @(negedge clk) hi_we = 1;
    @(negedge clk) hi_we = 0; per_wdata = 8'd3; lo_we = 1;
    @(negedge clk) lo_we = 0;
    s_ack_addr = 1; s_ack_data = 1; s_txbyte = 8'h96;
    cclr(8'h04);
    cset(8'h20);
    wait_irq("R13");
    wdat(8'hA4); cclr(8'h08);
    begin
      int hc = 0, lc = 0, n = 0;
      while (scl_oe && n < 500) begin @(negedge clk); n++; end
      while (!scl_oe && n < 500) begin @(negedge clk); hc++; n++; end
      while (scl_oe && n < 500) begin @(negedge clk); lc++; n++; end
      chk(hc == 5, "R13 SCL high count", 8'(hc), 8'd5);
      chk(lc == 3, "R13 SCL low count", 8'(lc), 8'd3);
    end
    wait_irq("R9");
    chk(stat_q == 8'h18, "R9 write address before repeat", stat_q, 8'h18);
    cset(8'h20); cclr(8'h08);
    wait_irq("R9");
    chk(stat_q == 8'h10, "R9 repeated start", stat_q, 8'h10);
    wdat(8'hA5); cclr(8'h08);
    wait_irq("R9");
    chk(stat_q == 8'h40, "R9 switch to read", stat_q, 8'h40);
    cclr(8'h08);
    wait_irq("R9");
    chk(stat_q == 8'h58 && dat_q == 8'h96, "R9 byte after switch", dat_q, 8'h96);
    do_stop();

    // R4 busy bus: another master's START
    bully = 1;
    repeat (4) @(negedge clk);
    cset(8'h20);
    repeat (60) @(negedge clk);
    chk(!irq && !scl_oe, "R4 waits while bus busy", {7'b0, irq}, 8'h00);
    bully = 0;
    wait_irq("R4");
    chk(stat_q == 8'h08, "R4 start after foreign stop", stat_q, 8'h08);
    do_stop();

    // R11 arbitration loss
    cset(8'h20);
    wait_irq("R11");
    wdat(8'hA4);
    bully = 1;
    cclr(8'h08);
    wait_irq("R11");
    chk(stat_q == 8'h38, "R11 lost status", stat_q, 8'h38);
    chk(!scl_oe && !sda_oe, "R11 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
    bully = 0;
    repeat (4) @(negedge clk);
    cclr(8'h08);
    @(negedge clk);
    chk(stat_q == 8'hF8 && !irq, "R2 clear-write clears flag", stat_q, 8'hF8);
    cset(8'h20);
    wait_irq("R11");
    chk(stat_q == 8'h08, "R11 ownership dropped, fresh start", stat_q, 8'h08);
    do_stop();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule